// File: doc/BRIEF.md
# Quad-Channel DAC Serial Command Front End

This block is the digital control logic in front of a four-channel voltage-output converter. A host writes 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. Each word holds a 4-bit command field in its upper bits and a 12-bit code below it. The block decodes the command when the select line returns high and updates four channels. Each channel is double-buffered: a staging latch receives new codes, and an output latch drives the converter code.

The serial pins are treated as asynchronous. They are sampled by the block clock through synchronizers, and edges of the serial clock and the select line are detected in the block clock domain. The shift register's most significant bit is driven on a serial output pin so that several devices can share one select line in a daisy chain. The output code width is set by the `DAC_W` parameter (8, 10 or 12 bits). Narrower widths keep the upper bits of the 12-bit data field.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: After `rst_n` is released, every output latch and staging latch reads zero, so all `dac_code` fields are 0.
- R2: A command with bits 15:14 = 00 writes the data field into the staging latch of the channel chosen by bits 13:12 (0 = channel A, the field at `dac_code` bits DAC_W-1:0). It leaves every output code unchanged.
- R3: A command with bits 15:14 = 01 copies the staging latch of the selected channel into its output latch. The data field of that word is not used.
- R4: A command with bits 15:14 = 10 writes the data field into both the staging latch and the output latch of the selected channel in one step.
- R5: A command with bits 15:14 = 11 is a broadcast. Bits 13:12 = 00, 01 or 10 apply the load, update or load-and-update action to all four channels at once, and 11 changes nothing.
- R6: A command takes effect only if exactly 16 rising serial clock edges arrived while select was low. A frame of any other length changes no latch.
- R7: Serial clock edges while select is high do not shift data and do not change `sdo`.
- R8: Words are sent MSB first. `sdo` changes only after falling serial clock edges and carries the bit shifted in 16 rising edges earlier, so the second half of a 32-bit frame reproduces the first word on `sdo`.
- R9: With DAC_W below 12, each output code equals the upper DAC_W bits of the 12-bit data field, and the lower bits are ignored.
- R10: Driving `clr_n` low clears all latches immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| clr_n | input | 1 | Active-low asynchronous latch clear |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, data sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Shift register MSB for daisy chaining |
| dac_code | output | 4*DAC_W | Four output codes, channel A in the lowest field |

## Verification
A bad value in a staging latch cannot be seen on `dac_code` until an update command moves it. For that reason, every load-only command is later followed by an update before the codes are compared. A miscounted bit counter or a wrongly decoded command field shows up within a few block clocks after select rises, either as a channel that changed when it should not have or as a channel that failed to change. Shift register damage appears on `sdo` after 16 serial clocks, and a 32-bit frame compares the whole delayed word. A second instance with 8-bit width runs on the same stimulus to check the truncation on every comparison.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int WORD_W = 16;
   localparam int DATA_W = 12;
   localparam int NUM_CH = 4;
   localparam int SEL_W  = 2;

   typedef enum logic [1:0] {
      ACT_LOAD   = 2'b00,
      ACT_UPDATE = 2'b01,
      ACT_BOTH   = 2'b10,
      ACT_BCAST  = 2'b11
   } act_e;
endpackage

// File: rtl/qdac_sync_edge.sv
module qdac_sync_edge #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES:0] chain_q;

   initial assert (STAGES >= 2) else $error("STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
      else        chain_q <= {chain_q[STAGES-1:0], d};
   end

   assign lvl  = chain_q[STAGES-1];
   assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
   import qdac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_low,
   input  logic              cs_rise,
   input  logic              cs_fall,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              sdi_s,
   output logic [WORD_W-1:0] word_q,
   output logic              word_vld,
   output logic              sdo
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] sreg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              shift_en, out_en, commit;

   assign shift_en = sck_rise & cs_low;
   assign out_en   = sck_fall & cs_low;
   assign commit   = cs_rise & (cnt_q == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q   <= '0;
         cnt_q    <= '0;
         sdo      <= 1'b0;
         word_q   <= '0;
         word_vld <= 1'b0;
      end else begin
         if (cs_fall) begin
            cnt_q <= '0;
         end else if (shift_en) begin
            sreg_q <= {sreg_q[WORD_W-2:0], sdi_s};
            if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
         end
         if (out_en) sdo <= sreg_q[WORD_W-1];
         word_vld <= commit;
         if (commit) word_q <= sreg_q;
      end
   end

   AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> $stable(sdo)); // R8
   AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_low |=> $stable(sreg_q)); // R7
   AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && cnt_q != CNT_FULL) |=> !word_vld); // R6
endmodule

// File: rtl/qdac_decoder.sv
module qdac_decoder
   import qdac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_q,
   input  logic              word_vld,
   output logic [NUM_CH-1:0] ld_en,
   output logic [NUM_CH-1:0] upd_en,
   output logic [DATA_W-1:0] data
);
   act_e             act;
   logic [SEL_W-1:0] sel;

   assign act  = act_e'(word_q[WORD_W-1 -: 2]);
   assign sel  = word_q[WORD_W-3 -: SEL_W];
   assign data = word_q[DATA_W-1:0];

   always_comb begin
      ld_en  = '0;
      upd_en = '0;
      if (word_vld) begin
         case (act)
            ACT_LOAD:   ld_en[sel] = 1'b1;
            ACT_UPDATE: upd_en[sel] = 1'b1;
            ACT_BOTH: begin
               ld_en[sel]  = 1'b1;
               upd_en[sel] = 1'b1;
            end
            default: begin
               case (sel)
                  2'b00: ld_en = '1;
                  2'b01: upd_en = '1;
                  2'b10: begin
                     ld_en  = '1;
                     upd_en = '1;
                  end
                  default: ;
               endcase
            end
         endcase
      end
   end

   AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && act != ACT_BCAST) |-> $onehot(ld_en | upd_en)); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> (ld_en == '0 && upd_en == '0)); // R6
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
   parameter int DAC_W  = 12,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              ld,
   input  logic              upd,
   input  logic [DATA_W-1:0] data_in,
   output logic [DAC_W-1:0]  code
);
   logic [DAC_W-1:0] trim;
   logic [DAC_W-1:0] inp_q, dac_q;

   generate
      if (DAC_W == DATA_W) begin : g_full
         assign trim = data_in;
      end else begin : g_trunc
         logic unused_lsbs;
         assign trim        = data_in[DATA_W-1 -: DAC_W];
         assign unused_lsbs = ^data_in[DATA_W-DAC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         inp_q <= '0;
         dac_q <= '0;
      end else begin
         if (ld)  inp_q <= trim;
         if (upd) dac_q <= ld ? trim : inp_q;
      end
   end

   assign code = dac_q;

   AST_LOAD_HOLDS_OUT: assert property (@(posedge clk) disable iff (!arst_n)
      (ld && !upd) |=> $stable(dac_q)); // R2
   AST_UPD_COPIES: assert property (@(posedge clk) disable iff (!arst_n)
      (upd && !ld) |=> dac_q == $past(inp_q)); // R3
   AST_BOTH_SAME: assert property (@(posedge clk) disable iff (!arst_n)
      (upd && ld) |=> (dac_q == inp_q)); // R4
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
   import qdac_pkg::*;
#(
   parameter int DAC_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_n,
   input  logic                    cs_n,
   input  logic                    sck,
   input  logic                    sdi,
   output logic                    sdo,
   output logic [NUM_CH*DAC_W-1:0] dac_code
);
   initial assert (DAC_W == 8 || DAC_W == 10 || DAC_W == 12)
      else $error("DAC_W must be 8, 10 or 12");

   logic cs_lvl, cs_rise, cs_fall;
   logic sck_lvl_unused, sck_rise, sck_fall;
   logic sdi_s, sdi_rise_unused, sdi_fall_unused;
   logic [WORD_W-1:0] word_q;
   logic              word_vld;
   logic [NUM_CH-1:0] ld_en, upd_en;
   logic [DATA_W-1:0] data;
   logic              latch_rst_n;

   assign latch_rst_n = rst_n & clr_n;

   qdac_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n),
      .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));
   qdac_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck),
      .lvl(sck_lvl_unused), .rise(sck_rise), .fall(sck_fall));
   qdac_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
      .clk(clk), .rst_n(rst_n), .d(sdi),
      .lvl(sdi_s), .rise(sdi_rise_unused), .fall(sdi_fall_unused));

   qdac_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .cs_low(~cs_lvl), .cs_rise(cs_rise),
      .cs_fall(cs_fall), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .sdi_s(sdi_s), .word_q(word_q), .word_vld(word_vld), .sdo(sdo));

   qdac_decoder u_dec (
      .clk(clk), .rst_n(rst_n), .word_q(word_q), .word_vld(word_vld),
      .ld_en(ld_en), .upd_en(upd_en), .data(data));

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         qdac_channel #(.DAC_W(DAC_W), .DATA_W(DATA_W)) u_ch (
            .clk(clk), .arst_n(latch_rst_n), .ld(ld_en[ch]), .upd(upd_en[ch]),
            .data_in(data), .code(dac_code[ch*DAC_W +: DAC_W]));
      end
   endgenerate

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> dac_code == '0); // R10
   AST_NO_CMD_NO_CHANGE: assert property (@(posedge clk) disable iff (!latch_rst_n)
      !$past(word_vld) |-> $stable(dac_code)); // R6
endmodule

// File: tb/qdac_serial_ctrl_tb_top.sv
module qdac_serial_ctrl_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic sdo12, sdo8;
   logic [47:0] dac12;
   logic [31:0] dac8;
   int checks = 0, fails = 0;
   logic [11:0] exp_in [4];
   logic [11:0] exp_dac [4];
   logic [31:0] sdo_cap;

   qdac_serial_ctrl #(.DAC_W(12)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sck(sck),
      .sdi(sdi), .sdo(sdo12), .dac_code(dac12));
   qdac_serial_ctrl #(.DAC_W(8)) dut8_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sck(sck),
      .sdi(sdi), .sdo(sdo8), .dac_code(dac8));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic send(input logic [31:0] v, input int n);
      cs_n = 1'b0;
      tick(6);
      for (int i = 0; i < n; i++) begin
         sdi = v[n-1-i];
         tick(8);
         if (i < 32) sdo_cap[i] = sdo12;
         sck = 1'b1;
         tick(8);
         sck = 1'b0;
      end
      tick(6);
      cs_n = 1'b1;
      tick(12);
   endtask

   task automatic model(input logic [15:0] w);
      logic [1:0] act, sel;
      act = w[15:14];
      sel = w[13:12];
      if (act == 2'b00) exp_in[sel] = w[11:0];
      else if (act == 2'b01) exp_dac[sel] = exp_in[sel];
      else if (act == 2'b10) begin exp_in[sel] = w[11:0]; exp_dac[sel] = w[11:0]; end
      else begin
         for (int c = 0; c < 4; c++) begin
            if (sel == 2'b00) exp_in[c] = w[11:0];
            else if (sel == 2'b01) exp_dac[c] = exp_in[c];
            else if (sel == 2'b10) begin exp_in[c] = w[11:0]; exp_dac[c] = w[11:0]; end
         end
      end
   endtask

   task automatic check_dacs(input string req);
      for (int c = 0; c < 4; c++) begin
         chk(dac12[c*12 +: 12] == exp_dac[c], req, 32'(dac12[c*12 +: 12]), 32'(exp_dac[c]));
         chk(dac8[c*8 +: 8] == exp_dac[c][11:4], {req, "/R9"},
             32'(dac8[c*8 +: 8]), 32'(exp_dac[c][11:4]));
      end
   endtask

   task automatic cmd(input logic [15:0] w, input string req);
      send({16'h0, w}, 16);
      model(w);
      check_dacs(req);
   endtask

   initial begin
      logic [15:0] w;
      logic [15:0] exp16;
      logic        s;
      for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
      tick(4);
      rst_n = 1'b1;
      tick(4);
      check_dacs("R1");

      // R2, R3, R4 per channel
      for (int c = 0; c < 4; c++) begin
         w = {2'b00, 2'(c), 12'hA5C ^ 12'(c * 12'h111)};
         cmd(w, "R2");
         cmd({2'b01, 2'(c), 12'hFFF}, "R3");
         w = {2'b10, 2'(c), 12'h3C7 + 12'(c * 12'h2B1)};
         cmd(w, "R4");
         cmd({2'b00, 2'(c), 12'h0F0 + 12'(c)}, "R2");
      end
      // R5 broadcast
      cmd({4'b1100, 12'h9E1}, "R5");
      cmd({4'b1111, 12'h123}, "R5");
      cmd({4'b1101, 12'h000}, "R5");
      cmd({4'b1110, 12'h6D2}, "R5");
      cmd({4'b1111, 12'hFFF}, "R5");

      // R6 wrong lengths
      send({16'h0, 16'b10_00_1111_0000_1111} >> 1, 15);
      check_dacs("R6");
      send({15'h0, 16'b10_01_0101_0101_0101, 1'b1}, 17);
      check_dacs("R6");

      // R8 daisy chain and R6 32-bit frame ignored
      send({16'hA3C5, 16'h1234}, 32);
      for (int j = 0; j < 16; j++) begin
         exp16[15-j] = 1'b1 ^ 1'b0 ^ 1'b0;
         exp16[15-j] = (32'hA3C51234 >> (31 - j)) & 32'h1;
      end
      chk(sdo_cap[31:16] == {<<{exp16}}, "R8", 32'(sdo_cap[31:16]), 32'({<<{exp16}}));
      check_dacs("R6");

      // R7 clock edges while select high
      s = sdo12;
      sdi = 1'b1;
      for (int k = 0; k < 6; k++) begin
         sck = 1'b1; tick(8); sck = 1'b0; tick(8);
         chk(sdo12 == s, "R7", 32'(sdo12), 32'(s));
      end
      check_dacs("R7");
      cmd({4'b1110, 12'h5A5}, "R7");

      // R9 sweep of data values on channel B
      for (int k = 0; k < 64; k++) cmd({4'b1001, 12'(k * 64 + k)}, "R9");

      // R10 immediate clear
      cmd({4'b1110, 12'hBEE}, "R5");
      @(negedge clk);
      #2 clr_n = 1'b0;
      #1;
      chk(dac12 == '0, "R10", dac12[31:0], 32'h0);
      chk(dac8 == '0, "R10", dac8, 32'h0);
      for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
      tick(3);
      clr_n = 1'b1;
      tick(3);
      cmd({4'b1101, 12'h777}, "R10");

      // R1 reset again
      cmd({4'b1110, 12'h321}, "R4");
      rst_n = 1'b0;
      tick(2);
      for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
      rst_n = 1'b1;
      tick(4);
      check_dacs("R1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog got=hang exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule